// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master controlled through a small word-addressed register file. Software sets the frame length, the clock divider and a frame count. It then writes words into a transmit FIFO. While the block is enabled, a sequencer takes one word at a time and shifts it out on the serial data line, most significant bit first, in clock mode 0. It collects the returning bits into a receive FIFO. The single active-low chip select is driven automatically. It falls for every frame and can either stay low across the whole counted group of frames or rise between frames.

When the last frame of a counted group finishes, the block sets the transmit-done and receive-ready events. It then reloads its frame counter and raises chip select. If the receive FIFO is already full at the end of a frame, the new word is dropped and an overflow event is recorded instead. The three events are latched in a raw interrupt register and gated by enable bits held in the control word. The gated result is kept in a sticky masked register that drives one interrupt line. Storage for both FIFOs sits inside the block. A big-FIFO option scales the usable depth to the frame length.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, reads return 0x80000102 at offset 0 (control), 0x4 at offset 1 (frame size), 0x7 at offset 6 (clock divider), 0x2440 at offset 2 (status) and 0 at offset 9 (raw events). The chip select output is high and the interrupt line is low.
- R2: Offsets 3, 6, 7 and 10 to 15 read back the last word written to them. Writes to offsets 2 (status), 8 (masked events) and 9 (raw events) change nothing. A read of offset 5 (TX data) returns 0.
- R3: Writes to offset 1 are ignored while control bit 0 (enable) is set. The frame length is bits 4:0 of offset 1, and a value of 0 means 32 bits.
- R4: A frame starts only when the block is enabled, the TX FIFO holds a word and the frame counter is non-zero. The low frame-length bits of the word go out MSB first on rising-edge-sampled mode 0. The receive line is sampled on each rising SCLK edge and stored right-aligned. Each SCLK half period lasts (offset 6 bits 7:0 + 1) clock cycles.
- R5: Chip select is low during every frame. With control bit 26 set, it stays low between the frames of one counted group. With bit 26 clear, it goes high after every frame.
- R6: Writing control loads the frame counter from control bits 23:8, and each frame decrements it. When the counter reaches zero, it reloads, chip select goes high, and bit 0 (TX done) and bit 1 (RX ready) are set in status and in the raw event register. Both status bits clear when a frame starts.
- R7: A frame that ends while the RX FIFO is at its depth drops the received word and sets bit 2 (overflow) in status and in the raw event register.
- R8: A read of offset 4 pops one RX word and clears status bit 2. Status shows RX full at bit 4, RX one-below-full at bit 5, RX empty at bit 6, TX full at bit 8, TX one-below-full at bit 9, TX empty at bit 10, chip select at bit 13 and frame in progress at bit 14.
- R9: Control bit 5 enables TX done (raw bit 0), bit 4 enables RX ready (raw bit 1) and bit 6 enables overflow (raw bit 2). Masked bits accumulate enable AND raw, and the interrupt line is the OR of the masked bits. Writing 1 to bit n of offset 3 clears raw bit n and masked bit n.
- R10: The FIFO depth is 4 unless control bit 29 is set. When bit 29 is set, the depth is 32 for frames of up to 8 bits, 16 for frames of up to 16 bits and 8 otherwise. A TX write to a full FIFO is dropped.
- R11: Writing control with bit 31 set returns all registers, both FIFOs and the sequencer to their reset state at that clock edge, with chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Interrupt, OR of the masked event bits |

## Verification
Several properties are checked on every cycle: the frame length stays frozen while the block is enabled, chip select is low whenever the shifter is busy, and chip select is high on the edge where TX done rises. The assertions also check that an event clear takes effect on the next cycle, that a soft reset restores the control word and empties the TX FIFO, and that neither FIFO pops while empty. Other behaviours can only be shown by the bench's scenarios. These are the serial bit order and the receive alignment for random lengths and dividers, the count of chip-select pulses in hold and pulse modes, and the absence of TX done after a partial group. They also include the dropped fifth TX word, the dropped received word on overflow and the mapping of the enable bits onto the interrupt line.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int REG_W = 32;

   localparam logic [3:0] A_CTRL  = 4'd0;
   localparam logic [3:0] A_FSIZE = 4'd1;
   localparam logic [3:0] A_STAT  = 4'd2;
   localparam logic [3:0] A_ICLR  = 4'd3;
   localparam logic [3:0] A_RXD   = 4'd4;
   localparam logic [3:0] A_TXD   = 4'd5;
   localparam logic [3:0] A_CKDIV = 4'd6;
   localparam logic [3:0] A_MIS   = 4'd8;
   localparam logic [3:0] A_RAW   = 4'd9;

   localparam logic [REG_W-1:0] CTRL_RST  = 32'h8000_0102;
   localparam logic [REG_W-1:0] FSIZE_RST = 32'h0000_0004;
   localparam logic [REG_W-1:0] CKDIV_RST = 32'h0000_0007;

   localparam int C_EN    = 0;
   localparam int C_IE_RX = 4;
   localparam int C_IE_TX = 5;
   localparam int C_IE_OV = 6;
   localparam int C_HOLD  = 26;
   localparam int C_BIG   = 29;
   localparam int C_SRST  = 31;
   localparam int FC_LO   = 8;
   localparam int FC_HI   = 23;

   // event bit order shared by status, raw, masked and clear registers
   localparam int E_TXDONE = 0;
   localparam int E_RXRDY  = 1;
   localparam int E_OVF    = 2;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic                         pop,
   input  logic [W-1:0]                 din,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spim_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;  rp_q <= '0;  count <= '0;
      end else if (clr) begin
         wp_q <= '0;  rp_q <= '0;  count <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout = mem[rp_q];

   // R10: occupancy never exceeds physical storage
   a_r10_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R8: no pop from an empty FIFO
   a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
   parameter int W     = 32,
   parameter int DIV_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   start,
   input  logic [W-1:0]           tx_word,
   input  logic [$clog2(W):0]     len,
   input  logic [DIV_W-1:0]       div,
   input  logic                   miso,
   output logic                   busy,
   output logic                   done,
   output logic                   sclk,
   output logic                   mosi,
   output logic [W-1:0]           rx_word
);
   localparam int LW = $clog2(W) + 1;

   logic [DIV_W:0] tick_q;
   logic [W-1:0]   txs_q, rxs_q;
   logic [LW-1:0]  left_q;
   logic           half_end;

   assign half_end = (tick_q == {1'b0, div});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; done <= 1'b0; sclk <= 1'b0; tick_q <= '0;
         txs_q <= '0;  rxs_q <= '0;  left_q <= '0;
      end else if (clr) begin
         busy <= 1'b0; done <= 1'b0; sclk <= 1'b0; tick_q <= '0;
         txs_q <= '0;  rxs_q <= '0;  left_q <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy   <= 1'b1;
            sclk   <= 1'b0;
            tick_q <= '0;
            left_q <= len;
            txs_q  <= tx_word << (LW'(W) - len);
            rxs_q  <= '0;
         end else if (busy) begin
            if (half_end) begin
               tick_q <= '0;
               if (!sclk) begin
                  sclk  <= 1'b1;
                  rxs_q <= {rxs_q[W-2:0], miso};
               end else begin
                  sclk   <= 1'b0;
                  txs_q  <= txs_q << 1;
                  left_q <= left_q - 1'b1;
                  if (left_q == LW'(1)) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end
               end
            end else begin
               tick_q <= tick_q + 1'b1;
            end
         end
      end
   end

   assign mosi    = txs_q[W-1];
   assign rx_word = rxs_q;

   // R4: serial clock is back at its idle level when a frame ends
   a_r4_sclk_idle_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !sclk);
   // R3: a frame never starts with zero length
   a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |-> len != '0);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int FIFO_MAX    = 32,
   parameter int SMALL_DEPTH = 4,
   parameter int DIV_W       = 8,
   parameter bit BIG_FIFO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n,
   output logic              irq
);
   localparam int NREG = 2 ** ADDR_W;
   localparam int CW   = $clog2(FIFO_MAX + 1);
   localparam int LW   = $clog2(REG_W) + 1;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("spim_ctrl: ADDR_W must be at least 4");
      end
      if (FIFO_MAX < 8 || SMALL_DEPTH > FIFO_MAX || SMALL_DEPTH < 2) begin : g_bad_fifo
         $error("spim_ctrl: FIFO sizing parameters out of range");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("spim_ctrl: DIV_W out of range");
      end
   endgenerate

   logic [REG_W-1:0] ctrl_q, fsize_q;
   logic [REG_W-1:0] store_q [NREG];
   logic [15:0]      fcnt_q;
   logic [2:0]       st_q, raw_q, mis_q, raw_n, mis_n, clr_bits, ien;
   logic             cs_q;

   logic wr, rd, wr_ctrl, wr_fsize, wr_iclr, sw_clr, plain_addr;
   assign wr       = bus_sel && bus_wr;
   assign rd       = bus_sel && !bus_wr;
   assign wr_ctrl  = wr && bus_addr == ADDR_W'(A_CTRL);
   assign wr_fsize = wr && bus_addr == ADDR_W'(A_FSIZE);
   assign wr_iclr  = wr && bus_addr == ADDR_W'(A_ICLR);
   assign sw_clr   = wr_ctrl && bus_wdata[C_SRST];
   assign plain_addr = !(bus_addr == ADDR_W'(A_CTRL) || bus_addr == ADDR_W'(A_FSIZE) ||
                         bus_addr == ADDR_W'(A_STAT) || bus_addr == ADDR_W'(A_RXD)  ||
                         bus_addr == ADDR_W'(A_TXD)  || bus_addr == ADDR_W'(A_MIS)  ||
                         bus_addr == ADDR_W'(A_RAW));

   // frame length and depth selection
   logic [LW-1:0] flen;
   logic [CW-1:0] depth;
   assign flen = (fsize_q[4:0] == 5'd0) ? LW'(REG_W) : LW'(fsize_q[4:0]);

   function automatic logic [CW-1:0] big_depth(input logic [LW-1:0] n);
      if (n <= LW'(8))       return CW'(FIFO_MAX);
      else if (n <= LW'(16)) return CW'(FIFO_MAX / 2);
      else                   return CW'(FIFO_MAX / 4);
   endfunction

   generate
      if (BIG_FIFO_EN) begin : g_big
         assign depth = ctrl_q[C_BIG] ? big_depth(flen) : CW'(SMALL_DEPTH);
      end else begin : g_fixed
         assign depth = CW'(SMALL_DEPTH);
      end
   endgenerate

   // FIFOs and shifter
   logic [CW-1:0]    tx_cnt, rx_cnt;
   logic [REG_W-1:0] tx_dout, rx_dout, sh_rx;
   logic tx_full, tx_empty, rx_full, rx_empty, tx_nxt, rx_nxt;
   logic tx_push, tx_pop, rx_push, rx_pop, start, sh_busy, sh_done, last, ovf_evt;

   assign tx_full  = tx_cnt >= depth;
   assign rx_full  = rx_cnt >= depth;
   assign tx_empty = tx_cnt == '0;
   assign rx_empty = rx_cnt == '0;
   assign tx_nxt   = tx_cnt == depth - 1'b1;
   assign rx_nxt   = rx_cnt == depth - 1'b1;

   assign tx_push = wr && bus_addr == ADDR_W'(A_TXD) && !tx_full;
   assign start   = ctrl_q[C_EN] && !tx_empty && fcnt_q != '0 && !sh_busy && !sh_done;
   assign tx_pop  = start;
   assign rx_pop  = rd && bus_addr == ADDR_W'(A_RXD) && !rx_empty;
   assign rx_push = sh_done && !rx_full;
   assign ovf_evt = sh_done && rx_full;
   assign last    = sh_done && fcnt_q == 16'd1;

   spim_fifo #(.W(REG_W), .DEPTH(FIFO_MAX)) u_txq (
      .clk, .rst_n, .clr(sw_clr), .push(tx_push), .pop(tx_pop),
      .din(bus_wdata), .dout(tx_dout), .count(tx_cnt));

   spim_fifo #(.W(REG_W), .DEPTH(FIFO_MAX)) u_rxq (
      .clk, .rst_n, .clr(sw_clr), .push(rx_push), .pop(rx_pop),
      .din(sh_rx), .dout(rx_dout), .count(rx_cnt));

   spim_shift #(.W(REG_W), .DIV_W(DIV_W)) u_shift (
      .clk, .rst_n, .clr(sw_clr), .start, .tx_word(tx_dout), .len(flen),
      .div(store_q[A_CKDIV][DIV_W-1:0]), .miso(spi_miso), .busy(sh_busy),
      .done(sh_done), .sclk(spi_sclk), .mosi(spi_mosi), .rx_word(sh_rx));

   // event logic
   assign ien      = {ctrl_q[C_IE_OV], ctrl_q[C_IE_RX], ctrl_q[C_IE_TX]};
   assign clr_bits = wr_iclr ? bus_wdata[2:0] : 3'b000;

   always_comb begin
      raw_n = raw_q & ~clr_bits;
      if (last)    raw_n[E_RXRDY:E_TXDONE] = 2'b11;
      if (ovf_evt) raw_n[E_OVF] = 1'b1;
      mis_n = (mis_q & ~clr_bits) | (ien & raw_n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST; fsize_q <= FSIZE_RST; fcnt_q <= 16'd1;
         st_q <= '0; raw_q <= '0; mis_q <= '0; cs_q <= 1'b1;
         for (int i = 0; i < NREG; i++) store_q[i] <= (i == int'(A_CKDIV)) ? CKDIV_RST : '0;
      end else if (sw_clr) begin
         ctrl_q <= CTRL_RST; fsize_q <= FSIZE_RST; fcnt_q <= 16'd1;
         st_q <= '0; raw_q <= '0; mis_q <= '0; cs_q <= 1'b1;
         for (int i = 0; i < NREG; i++) store_q[i] <= (i == int'(A_CKDIV)) ? CKDIV_RST : '0;
      end else begin
         if (wr && plain_addr) store_q[bus_addr] <= bus_wdata;
         if (wr_ctrl) ctrl_q <= bus_wdata;
         if (wr_fsize && !ctrl_q[C_EN]) fsize_q <= bus_wdata;

         if (wr_ctrl)      fcnt_q <= bus_wdata[FC_HI:FC_LO];
         else if (last)    fcnt_q <= ctrl_q[FC_HI:FC_LO];
         else if (sh_done) fcnt_q <= fcnt_q - 1'b1;

         if (start) cs_q <= 1'b0;
         else if (sh_done && (last || !ctrl_q[C_HOLD])) cs_q <= 1'b1;

         if (start)   st_q[E_RXRDY:E_TXDONE] <= 2'b00;
         if (last)    st_q[E_RXRDY:E_TXDONE] <= 2'b11;
         if (ovf_evt)     st_q[E_OVF] <= 1'b1;
         else if (rx_pop) st_q[E_OVF] <= 1'b0;

         raw_q <= raw_n;
         mis_q <= mis_n;
      end
   end

   assign spi_cs_n = cs_q;
   assign irq      = |mis_q;

   logic [31:0] status;
   assign status = {17'd0, sh_busy, cs_q, 2'b00, tx_empty, tx_nxt, tx_full, 1'b0,
                    rx_empty, rx_nxt, rx_full, 1'b0, st_q};

   always_comb begin
      case (bus_addr)
         ADDR_W'(A_CTRL):  bus_rdata = ctrl_q;
         ADDR_W'(A_FSIZE): bus_rdata = fsize_q;
         ADDR_W'(A_STAT):  bus_rdata = status;
         ADDR_W'(A_RXD):   bus_rdata = rx_empty ? '0 : rx_dout;
         ADDR_W'(A_TXD):   bus_rdata = '0;
         ADDR_W'(A_MIS):   bus_rdata = {29'd0, mis_q};
         ADDR_W'(A_RAW):   bus_rdata = {29'd0, raw_q};
         default:          bus_rdata = store_q[bus_addr];
      endcase
   end

   // R3: frame size holds while enabled
   a_r3_fsize_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[C_EN] && $past(ctrl_q[C_EN])) |-> $stable(fsize_q));
   // R5: chip select low whenever bits are shifting
   a_r5_cs_low_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> !spi_cs_n);
   // R6: TX done only appears together with chip select released
   a_r6_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[E_TXDONE]) |-> spi_cs_n);
   // R9: clearing a raw event takes effect on the next cycle
   a_r9_clear_raw: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_iclr && bus_wdata[E_TXDONE] && !last) |=> !raw_q[E_TXDONE]);
   // R11: soft reset restores control and empties the TX queue
   a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> (ctrl_q == CTRL_RST && spi_cs_n && tx_cnt == '0 && !irq));
endmodule

// File: tb/test_spim_ctrl.sv
module test_spim_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n, irq;

   int nchk = 0, nfail = 0;
   logic [31:0] cap = '0;
   logic        sclk_d = 1'b0, cs_d = 1'b1;
   int          cs_rise = 0;

   always #2 clk = ~clk;   // 250 MHz

   assign spi_miso = ~spi_mosi;   // inverting loopback

   spim_ctrl i_spim_ctrl (
      .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .spi_sclk, .spi_mosi, .spi_miso, .spi_cs_n, .irq);

   // serial monitor: sampled on the system clock, sees pre-edge values
   always @(posedge clk) begin
      sclk_d <= spi_sclk;
      cs_d   <= spi_cs_n;
      if (cs_d && !spi_cs_n)       cap <= '0;
      else if (spi_sclk && !sclk_d) cap <= {cap[30:0], spi_mosi};
      if (!cs_d && spi_cs_n) cs_rise <= cs_rise + 1;
   end

   function automatic logic [31:0] lmask(input int len);
      return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_done();
      logic [31:0] s;
      for (int i = 0; i < 5000; i++) begin
         rd(4'd2, s);
         if (s[0]) break;
      end
   endtask

   task automatic srst();
      wr(4'd0, 32'h8000_0000);
   endtask

   localparam logic [31:0] EN = 32'h1, HOLD = 32'h1 << 26, BIG = 32'h1 << 29;

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] v, w;
      logic [31:0] words [5];
      int c0;
      void'($urandom(32'd20240611));
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(4'd0, v); chk("R1 control", v, 32'h8000_0102);
      rd(4'd1, v); chk("R1 frame size", v, 32'h4);
      rd(4'd6, v); chk("R1 divider", v, 32'h7);
      rd(4'd2, v); chk("R1 status", v, 32'h2440);
      rd(4'd9, v); chk("R1 raw", v, 32'h0);
      chk("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
      chk("R1 irq", {31'd0, irq}, 32'd0);

      // R2 plain storage and read-only registers
      wr(4'd12, 32'hDEAD_BEEF); rd(4'd12, v); chk("R2 plain storage", v, 32'hDEAD_BEEF);
      wr(4'd7, 32'h0000_00A5);  rd(4'd7, v);  chk("R2 slave select storage", v, 32'hA5);
      wr(4'd2, 32'hFFFF_FFFF);  rd(4'd2, v);  chk("R2 status write ignored", v, 32'h2440);
      wr(4'd9, 32'h7);          rd(4'd9, v);  chk("R2 raw write ignored", v, 32'h0);
      wr(4'd8, 32'h7);          rd(4'd8, v);  chk("R2 masked write ignored", v, 32'h0);
      chk("R2 irq after masked write", {31'd0, irq}, 32'd0);
      rd(4'd5, v); chk("R2 tx read zero", v, 32'h0);

      // R4 single frame, directed
      srst();
      wr(4'd1, 32'd8); wr(4'd6, 32'd1); wr(4'd0, EN | (32'd1 << 8));
      wr(4'd5, 32'h0000_01A5);
      wait_done();
      chk("R4 mosi bits", cap & 32'hFF, 32'hA5);
      rd(4'd4, v); chk("R4 rx word", v, 32'h5A);
      rd(4'd2, v); chk("R8 rx empty after pop", v & 32'h40, 32'h40);

      // R3 zero length means 32 bits
      srst();
      wr(4'd1, 32'd0); wr(4'd6, 32'd0); wr(4'd0, EN | (32'd1 << 8));
      wr(4'd5, 32'h8000_0001);
      wait_done();
      chk("R3 32-bit frame out", cap, 32'h8000_0001);
      rd(4'd4, v); chk("R3 32-bit frame in", v, 32'h7FFF_FFFE);

      // R4 random lengths and dividers
      for (int it = 0; it < 20; it++) begin
         int len, dv;
         len = 1 + int'($urandom % 31);
         dv  = int'($urandom % 4);
         w   = $urandom;
         srst();
         wr(4'd1, len); wr(4'd6, dv); wr(4'd0, EN | (32'd1 << 8));
         wr(4'd5, w);
         wait_done();
         chk("R4 random out", cap & lmask(len), w & lmask(len));
         rd(4'd4, v); chk("R4 random in", v, ~w & lmask(len));
      end

      // R6 partial group in hold mode, then completion
      srst();
      wr(4'd1, 32'd8); wr(4'd6, 32'd1); wr(4'd0, EN | HOLD | (32'd3 << 8));
      c0 = cs_rise;
      wr(4'd5, 32'h11); wr(4'd5, 32'h22);
      idle(300);
      rd(4'd2, v);
      chk("R6 no done after partial group", v & 32'h3, 32'h0);
      chk("R6 tx drained", v & 32'h400, 32'h400);
      chk("R5 hold keeps cs low", {31'd0, spi_cs_n}, 32'd0);
      wr(4'd5, 32'h33);
      wait_done();
      idle(2);
      chk("R5 hold one cs pulse", cs_rise - c0, 32'd1);
      rd(4'd9, v); chk("R6 raw done bits", v, 32'h3);
      chk("R6 cs high at end", {31'd0, spi_cs_n}, 32'd1);

      // R5 pulse mode
      srst();
      wr(4'd1, 32'd8); wr(4'd6, 32'd0); wr(4'd0, EN | (32'd3 << 8));
      c0 = cs_rise;
      wr(4'd5, 32'h44); idle(40); wr(4'd5, 32'h55); idle(40); wr(4'd5, 32'h66);
      wait_done();
      idle(2);
      chk("R5 pulse cs per frame", cs_rise - c0, 32'd3);

      // R7 overflow at depth 4
      srst();
      wr(4'd1, 32'd8); wr(4'd6, 32'd0); wr(4'd0, EN | (32'd5 << 8));
      for (int i = 0; i < 5; i++) words[i] = $urandom & 32'hFF;
      for (int i = 0; i < 4; i++) wr(4'd5, words[i]);
      idle(150);
      wr(4'd5, words[4]);
      wait_done();
      rd(4'd2, v);
      chk("R7 overflow status", v & 32'h14, 32'h14);
      rd(4'd9, v); chk("R7 overflow raw", v, 32'h7);
      rd(4'd4, v); chk("R7 oldest word kept", v, ~words[0] & 32'hFF);
      rd(4'd2, v); chk("R8 pop clears overflow and full", v & 32'h14, 32'h0);
      rd(4'd9, v); chk("R8 raw overflow stays", v, 32'h7);

      // R10 TX drop when full at depth 4
      srst();
      wr(4'd1, 32'd8); wr(4'd6, 32'd0); wr(4'd0, 32'd5 << 8);
      for (int i = 0; i < 5; i++) wr(4'd5, 32'h10 + i);
      rd(4'd2, v); chk("R10 tx full at 4", v & 32'h700, 32'h100);
      wr(4'd0, EN | (32'd5 << 8));
      idle(300);
      rd(4'd2, v); chk("R10 fifth word dropped", v & 32'h401, 32'h400);
      for (int i = 0; i < 4; i++) begin
         rd(4'd4, v); chk("R8 rx order", v, ~(32'h10 + i) & 32'hFF);
      end
      rd(4'd2, v); chk("R8 rx empty", v & 32'h70, 32'h40);

      // R10 big FIFO, depth 16 for 12-bit frames; R3 frozen size
      srst();
      wr(4'd1, 32'd12); wr(4'd0, BIG | (32'd1 << 8));
      for (int i = 0; i < 15; i++) wr(4'd5, i);
      rd(4'd2, v); chk("R10 big depth one below full", v & 32'h300, 32'h200);
      wr(4'd5, 32'h99);
      rd(4'd2, v); chk("R10 big depth full", v & 32'h300, 32'h100);
      wr(4'd0, BIG | (32'd1 << 8) | 32'h10000);
      wr(4'd0, EN | BIG);
      wr(4'd1, 32'd3);
      rd(4'd1, v); chk("R3 size ignored while enabled", v, 32'd12);

      // R9 interrupt mapping and clearing
      srst();
      wr(4'd1, 32'd8); wr(4'd6, 32'd0);
      wr(4'd0, EN | (32'd1 << 4) | (32'd1 << 5) | (32'd1 << 8));
      wr(4'd5, 32'h3C);
      wait_done(); idle(2);
      rd(4'd8, v); chk("R9 masked both", v, 32'h3);
      chk("R9 irq high", {31'd0, irq}, 32'd1);
      wr(4'd3, 32'h1);
      rd(4'd9, v); chk("R9 raw partial clear", v, 32'h2);
      rd(4'd8, v); chk("R9 masked partial clear", v, 32'h2);
      chk("R9 irq still high", {31'd0, irq}, 32'd1);
      wr(4'd3, 32'h2);
      rd(4'd9, v); chk("R9 raw cleared", v, 32'h0);
      chk("R9 irq low", {31'd0, irq}, 32'd0);
      srst();
      wr(4'd1, 32'd8); wr(4'd6, 32'd0);
      wr(4'd0, EN | (32'd1 << 6) | (32'd1 << 8));
      wr(4'd5, 32'h3C);
      wait_done(); idle(2);
      rd(4'd8, v); chk("R9 only overflow enabled", v, 32'h0);
      chk("R9 irq stays low", {31'd0, irq}, 32'd0);

      // R11 soft reset with data queued
      wr(4'd6, 32'd3); wr(4'd12, 32'h1234);
      wr(4'd0, 32'd1 << 8);
      wr(4'd5, 32'h77);
      srst();
      rd(4'd0, v); chk("R11 control", v, 32'h8000_0102);
      rd(4'd1, v); chk("R11 size", v, 32'h4);
      rd(4'd6, v); chk("R11 divider", v, 32'h7);
      rd(4'd12, v); chk("R11 plain cleared", v, 32'h0);
      rd(4'd2, v); chk("R11 status", v, 32'h2440);
      rd(4'd9, v); chk("R11 raw", v, 32'h0);
      chk("R11 cs_n", {31'd0, spi_cs_n}, 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule